// File: doc/BRIEF.md
# Peripheral Shutdown Handshake Controller

This system-control block puts peripherals into an orderly stopped state, either for static power saving or ahead of a software reset. Software owns two registers reached through a plain strobe bus: a disable register with one bit per peripheral, and a suspend-select register that names the peripherals to stop while a debug halt is active. The block drives one shutdown request line per peripheral and collects one acknowledge line from each peripheral.

Some peripherals support the handshake and some do not. When a software reset is requested, the block enters a pre-reset phase. It raises a request on every handshake-capable peripheral and waits until all of them have acknowledged. It then emits a single-cycle completion pulse for the reset generator that follows. A peripheral can hold off its acknowledge, for example while a converter finishes a conversion or while a bus controller has granted the bus away. The block waits as long as that takes.

Reading the disable register returns the true shutdown state of each handshake-capable peripheral. For peripherals without a handshake, it returns the stored bit.

Top module: `periph_shutdown_ctrl`

## Requirements
- R1: After reset both registers are zero, every request line is low, the completion pulse is low and the read data is zero.
- R2: A write with address 0 loads the disable register. From the next cycle, every peripheral whose disable bit is 1 has its request line high.
- R3: A write with address 1 loads the suspend-select register. While the halt input is low, that register has no effect on the request lines.
- R4: While the halt input is high, every peripheral whose suspend-select bit is 1 has its request line high, as if it were disabled.
- R5: A read with address 0 returns, one cycle later, one bit per peripheral. For a handshake-capable peripheral the bit is its request line ANDed with its acknowledge. For a peripheral without a handshake (a 0 in the HS_MASK parameter) the bit is the stored disable bit.
- R6: A read with address 1 returns the suspend-select register one cycle later. Reads of addresses 2 and 3 return zero, and writes to them change nothing.
- R7: A software-reset request seen while idle raises the request line of every handshake-capable peripheral from the next cycle. The request lines of peripherals without a handshake are left as the registers set them.
- R8: The completion output is high for exactly one cycle. That cycle follows the clock edge at which the last outstanding acknowledge was sampled high. It is never high while any requested peripheral has not yet acknowledged.
- R9: A handshake-capable peripheral whose disable bit is already 1 when the pre-reset phase starts counts as acknowledged. If all of them are disabled, the completion pulse comes in the second cycle after the request.
- R10: During the cycle of the completion pulse, and from then on, the pre-reset requests are released and each request line shows only its register-driven value. Further software-reset requests while the pre-reset phase is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 disable, 1 suspend-select |
| wdata | input | NUM_PERIPH | Write data |
| rdata | output | NUM_PERIPH | Read data, updated the cycle after rd_en |
| sw_reset_req | input | 1 | Software reset request, one-cycle pulse |
| dbg_halt | input | 1 | Debug breakpoint active |
| sd_ack | input | NUM_PERIPH | Per-peripheral shutdown acknowledge |
| sd_req | output | NUM_PERIPH | Per-peripheral shutdown request |
| prereset_done | output | 1 | One-cycle pulse when the pre-reset phase ends |

## Verification
On every cycle, the assertions check that disabled peripherals and suspended peripherals under halt are always requested, and that no acknowledged peripheral ever returns to the pending set during a pre-reset phase. They also check that the completion pulse is one cycle long, that it never coincides with an unacknowledged peripheral, and that it arrives with the pre-reset requests already released. Some behaviour can only be shown by the bench scenarios: a converter that holds its acknowledge until its result is read, a bus controller that holds off while the bus is granted away, the case where every peripheral is already disabled, reset requests ignored mid-phase, and the per-bit readback that mixes status and stored values.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int unsigned SD_ADDR_W = 2;
  localparam logic [SD_ADDR_W-1:0] SD_ADDR_DIS  = 2'd0;
  localparam logic [SD_ADDR_W-1:0] SD_ADDR_SUSP = 2'd1;

  typedef enum logic [0:0] {
    PR_IDLE = 1'b0,
    PR_WAIT = 1'b1
  } pr_state_e;
endpackage

// File: rtl/sd_regs.sv
module sd_regs
  import sd_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [SD_ADDR_W-1:0]  addr,
  input  logic [NUM_PERIPH-1:0] wdata,
  input  logic [NUM_PERIPH-1:0] status_vec,
  output logic [NUM_PERIPH-1:0] dis_q,
  output logic [NUM_PERIPH-1:0] susp_q,
  output logic [NUM_PERIPH-1:0] rdata
);
  logic [NUM_PERIPH-1:0] rd_mux;

  always_comb begin
    unique case (addr)
      SD_ADDR_DIS:  rd_mux = status_vec;
      SD_ADDR_SUSP: rd_mux = susp_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis_q  <= '0;
      susp_q <= '0;
      rdata  <= '0;
    end else begin
      if (wr_en && addr == SD_ADDR_DIS)  dis_q  <= wdata;
      if (wr_en && addr == SD_ADDR_SUSP) susp_q <= wdata;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R6
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > SD_ADDR_SUSP) |=> ($stable(dis_q) && $stable(susp_q)));
endmodule

// File: rtl/sd_prereset.sv
module sd_prereset
  import sd_pkg::*;
#(
  parameter int unsigned         NUM_PERIPH = 8,
  parameter logic [NUM_PERIPH-1:0] HS_MASK  = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sw_reset_req,
  input  logic [NUM_PERIPH-1:0] dis_q,
  input  logic [NUM_PERIPH-1:0] sd_ack,
  output logic [NUM_PERIPH-1:0] pend_q,
  output logic                  busy,
  output logic                  done_q
);
  pr_state_e             state_q;
  logic [NUM_PERIPH-1:0] pend_nx;

  assign pend_nx = pend_q & ~sd_ack;
  assign busy    = (state_q == PR_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PR_IDLE;
      pend_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        PR_IDLE: begin
          if (sw_reset_req) begin
            state_q <= PR_WAIT;
            pend_q  <= HS_MASK & ~dis_q;
          end
        end
        PR_WAIT: begin
          if (pend_nx == '0) begin
            state_q <= PR_IDLE;
            pend_q  <= '0;
            done_q  <= 1'b1;
          end else begin
            pend_q <= pend_nx;
          end
        end
        default: state_q <= PR_IDLE;
      endcase
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8
  done_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ((pend_q & ~sd_ack) != '0)) |=> !done_q);

  // R8
  pend_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/sd_reqgen.sv
module sd_reqgen #(
  parameter int unsigned           NUM_PERIPH = 8,
  parameter logic [NUM_PERIPH-1:0] HS_MASK    = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] dis_q,
  input  logic [NUM_PERIPH-1:0] susp_q,
  input  logic                  dbg_halt,
  input  logic [NUM_PERIPH-1:0] pend_q,
  input  logic [NUM_PERIPH-1:0] sd_ack,
  output logic [NUM_PERIPH-1:0] static_req,
  output logic [NUM_PERIPH-1:0] sd_req,
  output logic [NUM_PERIPH-1:0] status_vec
);
  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_lane
    assign static_req[i] = dis_q[i] | (dbg_halt & susp_q[i]);
    if (HS_MASK[i]) begin : g_hs
      assign sd_req[i]     = static_req[i] | pend_q[i];
      assign status_vec[i] = sd_req[i] & sd_ack[i];
    end else begin : g_plain
      assign sd_req[i]     = static_req[i];
      assign status_vec[i] = dis_q[i];
    end
  end

  // R2
  disabled_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sd_req & dis_q) == dis_q));

  // R4
  halt_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt |-> ((sd_req & susp_q) == susp_q));
endmodule

// File: rtl/periph_shutdown_ctrl.sv
module periph_shutdown_ctrl
  import sd_pkg::*;
#(
  parameter int unsigned           NUM_PERIPH = 8,
  parameter logic [NUM_PERIPH-1:0] HS_MASK    = 8'b1011_0111
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [SD_ADDR_W-1:0]  addr,
  input  logic [NUM_PERIPH-1:0] wdata,
  output logic [NUM_PERIPH-1:0] rdata,
  input  logic                  sw_reset_req,
  input  logic                  dbg_halt,
  input  logic [NUM_PERIPH-1:0] sd_ack,
  output logic [NUM_PERIPH-1:0] sd_req,
  output logic                  prereset_done
);
  logic [NUM_PERIPH-1:0] dis_q, susp_q, pend_q, static_req, status_vec;
  logic                  busy;

  sd_regs #(.NUM_PERIPH(NUM_PERIPH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .status_vec(status_vec), .dis_q(dis_q), .susp_q(susp_q),
    .rdata(rdata)
  );

  sd_prereset #(.NUM_PERIPH(NUM_PERIPH), .HS_MASK(HS_MASK)) u_pre (
    .clk(clk), .rst_n(rst_n), .sw_reset_req(sw_reset_req), .dis_q(dis_q),
    .sd_ack(sd_ack), .pend_q(pend_q), .busy(busy), .done_q(prereset_done)
  );

  sd_reqgen #(.NUM_PERIPH(NUM_PERIPH), .HS_MASK(HS_MASK)) u_req (
    .clk(clk), .rst_n(rst_n), .dis_q(dis_q), .susp_q(susp_q),
    .dbg_halt(dbg_halt), .pend_q(pend_q), .sd_ack(sd_ack),
    .static_req(static_req), .sd_req(sd_req), .status_vec(status_vec)
  );

  // R7
  entry_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sw_reset_req && !wr_en) |=> ((sd_req & HS_MASK) == HS_MASK));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prereset_done |-> (sd_req == static_req));
endmodule

// File: tb/periph_shutdown_ctrl_bench.sv
`timescale 1ns/1ps
module periph_shutdown_ctrl_bench;
  localparam int N = 8;
  localparam logic [N-1:0] HS = 8'b1011_0111;
  localparam int CONV = 0;
  localparam int BUSC = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, sw_reset_req = 1'b0, dbg_halt = 1'b0;
  logic [1:0] addr = '0;
  logic [N-1:0] wdata = '0, sd_ack = '0;
  logic [N-1:0] rdata, sd_req;
  logic prereset_done;

  int n_chk = 0, n_fail = 0;
  logic wait_read = 1'b0, result_read = 1'b0, arb_en = 1'b0, hold_n = 1'b1;
  int ack_cnt [N];
  int done_seen = 0;

  // reference model state
  logic [N-1:0] m_dis = '0, m_susp = '0, m_pend = '0, m_rdata = '0;
  logic m_inpre = 1'b0, m_done = 1'b0;

  always #4 clk = ~clk;

  periph_shutdown_ctrl #(.NUM_PERIPH(N), .HS_MASK(HS)) u_periph_shutdown_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sw_reset_req(sw_reset_req),
    .dbg_halt(dbg_halt), .sd_ack(sd_ack), .sd_req(sd_req),
    .prereset_done(prereset_done)
  );

  function automatic logic [N-1:0] exp_req();
    return m_dis | (dbg_halt ? m_susp : '0) | m_pend;
  endfunction

  function automatic logic [N-1:0] exp_status();
    logic [N-1:0] r = exp_req();
    logic [N-1:0] s;
    for (int i = 0; i < N; i++) s[i] = HS[i] ? (r[i] & sd_ack[i]) : m_dis[i];
    return s;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  // reference model, behavioural
  always @(posedge clk) begin
    if (!rst_n) begin
      m_dis <= '0; m_susp <= '0; m_pend <= '0; m_rdata <= '0;
      m_inpre <= 1'b0; m_done <= 1'b0;
    end else begin
      m_done <= 1'b0;
      if (wr_en && addr == 2'd0) m_dis <= wdata;
      if (wr_en && addr == 2'd1) m_susp <= wdata;
      if (rd_en) m_rdata <= (addr == 2'd0) ? exp_status() : (addr == 2'd1) ? m_susp : '0;
      if (!m_inpre) begin
        if (sw_reset_req) begin m_inpre <= 1'b1; m_pend <= HS & ~m_dis; end
      end else if ((m_pend & ~sd_ack) == '0) begin
        m_inpre <= 1'b0; m_pend <= '0; m_done <= 1'b1;
      end else begin
        m_pend <= m_pend & ~sd_ack;
      end
    end
  end

  // every-cycle comparison
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      check("R2 R3 R4 R7 R10 sd_req", sd_req, exp_req());
      check("R8 R9 prereset_done", {{(N-1){1'b0}}, prereset_done}, {{(N-1){1'b0}}, m_done});
      check("R5 R6 rdata", rdata, m_rdata);
      if (prereset_done) done_seen++;
    end
  end

  // peripheral acknowledge models
  always @(negedge clk) begin
    #1;
    for (int i = 0; i < N; i++) begin
      ack_cnt[i] = sd_req[i] ? ack_cnt[i] + 1 : 0;
      sd_ack[i] <= sd_req[i] && (ack_cnt[i] > i)
                   && !(i == BUSC && arb_en && !hold_n)
                   && !(i == CONV && wait_read && !result_read);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_reset_req();
    @(negedge clk); sw_reset_req = 1'b1;
    @(negedge clk); sw_reset_req = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int k = 0; k < limit && done_seen == 0; k++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) ack_cnt[i] = 0;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 sd_req", sd_req, '0);
    check("R1 rdata", rdata, '0);
    check("R1 done", {{(N-1){1'b0}}, prereset_done}, '0);

    // R2 R5: mixed disable, non-handshake bits 3 and 6 read stored value
    wr(2'd0, 8'h4C);
    check("R2 sd_req", sd_req, 8'h4C);
    cyc(10);
    rd(2'd0);
    check("R5 readback", rdata, 8'h4C);

    // R3 R4 R6
    wr(2'd1, 8'h21);
    check("R3 no halt", sd_req, 8'h4C);
    @(negedge clk); dbg_halt = 1'b1;
    #1 check("R4 halt", sd_req, 8'h6D);
    cyc(8);
    rd(2'd0);
    check("R4 R5 readback halted", rdata, 8'h6D);
    rd(2'd1);
    check("R6 suspend read", rdata, 8'h21);
    rd(2'd2);
    check("R6 unmapped read", rdata, '0);
    wr(2'd3, 8'hFF);
    @(negedge clk); dbg_halt = 1'b0;
    #1 check("R6 unmapped write", sd_req, 8'h4C);

    // R7 R8: converter holding acknowledge until result read
    wait_read = 1'b1; result_read = 1'b0;
    done_seen = 0;
    pulse_reset_req();
    check("R7 all handshake requested", sd_req & HS, HS);
    cyc(20);
    check("R8 no done while converter busy", done_seen, 0);
    pulse_reset_req(); // R10: ignored mid-phase
    result_read = 1'b1;
    wait_done(40);
    check("R8 done after converter", done_seen, 1);
    cyc(5);
    check("R8 single pulse", done_seen, 1);
    check("R10 released", sd_req, 8'h4C);
    wait_read = 1'b0;

    // R8: bus controller holding off while bus granted away
    arb_en = 1'b1; hold_n = 1'b0; done_seen = 0;
    pulse_reset_req();
    cyc(20);
    check("R8 no done while bus held", done_seen, 0);
    hold_n = 1'b1;
    wait_done(40);
    check("R8 done after bus release", done_seen, 1);
    arb_en = 1'b0;
    cyc(4);

    // R9: all handshake peripherals pre-disabled
    wr(2'd0, HS);
    cyc(12);
    done_seen = 0;
    @(negedge clk); sw_reset_req = 1'b1;
    @(negedge clk); sw_reset_req = 1'b0;
    @(negedge clk);
    check("R9 done second cycle", done_seen, 1);
    cyc(5);
    check("R9 single pulse", done_seen, 1);

    cyc(5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule